// File: doc/BRIEF.md
# Serial Port Bit-Rate Tick Generator

This block turns the system clock into the two timing strobes a serial port needs: an oversampling tick, which a receiver uses to look at the line several times per bit, and a bit tick, which marks each bit boundary. Both strobes come from one free-running period counter. An 8-bit divisor X sets that counter's period to X+1 clock cycles. A small secondary divider then scales the counter's wrap pulses by one of three overall ratios. The ratio is picked by two mode pins: a synchronous/asynchronous select and a fast/slow select. The fast/slow select only matters in asynchronous mode.

Software or a neighbouring control block loads X through a one-cycle write strobe. A write takes effect at once. The period counter restarts from the new value and the secondary divider is cleared, so the first tick at the new rate never waits for an old period to finish. Both outputs are single-cycle, registered strobes. Nothing else is produced: shifting, framing and driving the serial clock pin belong to other blocks. The block moves no data stream and has no valid/ready handshake; every pin is a plain control level or strobe.

Top module: `brg_tick_gen`

## Requirements
- R1: While reset is held, both outputs are 0. Reset leaves the divisor and the period counter at 0. With asynchronous fast mode selected, the oversampling tick is therefore high on every cycle once reset has been released for a few cycles.
- R2: The period counter wraps once every X+1 clock cycles. In asynchronous fast mode (sync_mode=0, hi_speed=1) the oversampling tick comes once per wrap, which is every X+1 cycles.
- R3: In asynchronous fast mode the bit tick comes every 16·(X+1) cycles, which is once per 16 oversampling ticks.
- R4: In asynchronous slow mode (sync_mode=0, hi_speed=0) the oversampling tick comes every 4·(X+1) cycles and the bit tick every 64·(X+1) cycles.
- R5: In synchronous mode (sync_mode=1) the oversampling tick comes every X+1 cycles and the bit tick every 4·(X+1) cycles. This holds whatever the level of hi_speed.
- R6: A write (div_wr=1 at a rising edge) restarts all timing from that edge. Neither output is high in the cycle after the write. The k-th oversampling tick is high exactly k·P cycles after the write edge, where P is the mode's oversampling period. The k-th bit tick is high exactly k·B cycles after the write edge, where B is the mode's bit period.
- R7: Each tick is a one-cycle pulse whenever its period exceeds one cycle. A bit tick is always accompanied by an oversampling tick in the same cycle.
- R8: The divisor extremes behave like any other value. X=0 gives the fastest rate, with wraps every cycle. X=255 gives the slowest rate, with wraps every 256 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_wr | input | 1 | One-cycle strobe that loads div_val and restarts timing |
| div_val | input | 8 | Divisor X; period counter runs X+1 cycles |
| hi_speed | input | 1 | Asynchronous rate select: 1 fast (x16), 0 slow (x64); ignored in synchronous mode |
| sync_mode | input | 1 | 1 selects synchronous ratio (x4) |
| os_tick | output | 1 | Oversampling strobe, one cycle wide |
| bit_tick | output | 1 | Bit-boundary strobe, one cycle wide |

## Verification
The bench measures the exact cycle of the first and second oversampling and bit ticks after each write, in all three ratios. A design that miscounted X+1 against X, or that added a stray register stage, would be off by a fixed number of cycles and would be caught. It writes a new divisor in the middle of an old period. A design that did not restart would put its first tick at the old phase instead of exactly one period after the write. It runs synchronous mode with hi_speed both low and high. A design that let hi_speed leak into the synchronous ratio would change its bit period between the two runs. The divisor extremes 0 and 255 expose counters that skip their reload, and the bench also checks that ticks stay one cycle wide and that every bit tick falls on an oversampling tick.

// File: rtl/brg_pkg.sv
package brg_pkg;

  // Overall oscillator-to-bit ratio family selected by the mode pins.
  typedef enum logic [1:0] {
    RATIO_ASYNC_SLOW = 2'd0,
    RATIO_ASYNC_FAST = 2'd1,
    RATIO_SYNC       = 2'd2
  } brg_ratio_e;

endpackage

// File: rtl/brg_mode_decode.sv
module brg_mode_decode
  import brg_pkg::*;
#(
  parameter int SLOW_PRE  = 4,
  parameter int OS_ASYNC  = 16,
  parameter int OS_SYNC   = 4,
  localparam int PRE_W    = ($clog2(SLOW_PRE) > 0) ? $clog2(SLOW_PRE) : 1,
  localparam int OS_W     = ($clog2(OS_ASYNC) > 0) ? $clog2(OS_ASYNC) : 1
) (
  input  logic             hi_speed,
  input  logic             sync_mode,
  output logic [PRE_W-1:0] pre_last,
  output logic [OS_W-1:0]  os_last
);

  localparam logic [PRE_W-1:0] PRE_SLOW_LAST = PRE_W'(SLOW_PRE - 1);
  localparam logic [OS_W-1:0]  OS_ASYNC_LAST = OS_W'(OS_ASYNC - 1);
  localparam logic [OS_W-1:0]  OS_SYNC_LAST  = OS_W'(OS_SYNC - 1);

  brg_ratio_e ratio;

  // Synchronous mode wins; hi_speed only matters when asynchronous.
  always_comb begin
    if (sync_mode)     ratio = RATIO_SYNC;
    else if (hi_speed) ratio = RATIO_ASYNC_FAST;
    else               ratio = RATIO_ASYNC_SLOW;
  end

  always_comb begin
    case (ratio)
      RATIO_ASYNC_SLOW: begin
        pre_last = PRE_SLOW_LAST;
        os_last  = OS_ASYNC_LAST;
      end
      RATIO_ASYNC_FAST: begin
        pre_last = '0;
        os_last  = OS_ASYNC_LAST;
      end
      RATIO_SYNC: begin
        pre_last = '0;
        os_last  = OS_SYNC_LAST;
      end
      default: begin
        pre_last = '0;
        os_last  = OS_ASYNC_LAST;
      end
    endcase
  end

endmodule

// File: rtl/brg_period_counter.sv
module brg_period_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             wrap
);

  logic [CNT_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;

  assign wrap = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      div_q <= load_val;
      cnt_q <= load_val;
    end else if (wrap) begin
      cnt_q <= div_q;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R6: a write restarts the count from the new divisor on the next cycle
  p_load_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

  // R2: the down-count never runs above the stored divisor
  p_cnt_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_q);

  // R2: after a wrap with no write, the counter holds the full divisor
  p_wrap_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !load) |=> (cnt_q == div_q));

endmodule

// File: rtl/brg_subdiv.sv
module brg_subdiv #(
  parameter int PRE_W = 2,
  parameter int OS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wrap,
  input  logic [PRE_W-1:0] pre_last,
  input  logic [OS_W-1:0]  os_last,
  output logic             os_tick,
  output logic             bit_tick
);

  logic [PRE_W-1:0] pre_q;
  logic [OS_W-1:0]  os_q;
  logic             pre_hit;
  logic             os_hit;
  logic             os_pulse;
  logic             bit_pulse;

  // >= keeps the counters sane if the mode changes mid-period
  assign pre_hit   = (pre_q >= pre_last);
  assign os_hit    = (os_q >= os_last);
  assign os_pulse  = wrap && pre_hit;
  assign bit_pulse = os_pulse && os_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q    <= '0;
      os_q     <= '0;
      os_tick  <= 1'b0;
      bit_tick <= 1'b0;
    end else if (clear) begin
      pre_q    <= '0;
      os_q     <= '0;
      os_tick  <= 1'b0;
      bit_tick <= 1'b0;
    end else begin
      if (wrap)
        pre_q <= pre_hit ? '0 : pre_q + 1'b1;
      if (os_pulse)
        os_q <= os_hit ? '0 : os_q + 1'b1;
      os_tick  <= os_pulse;
      bit_tick <= bit_pulse;
    end
  end

  // R6: no strobe in the cycle right after a restart
  p_clear_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!os_tick && !bit_tick));

  // R7: a bit boundary always lands on an oversampling tick
  p_bit_on_os_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);

  // R2: an oversampling tick only follows a period-counter wrap
  p_os_after_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |-> $past(wrap));

endmodule

// File: rtl/brg_tick_gen.sv
module brg_tick_gen #(
  parameter int CNT_W    = 8,
  parameter int SLOW_PRE = 4,
  parameter int OS_ASYNC = 16,
  parameter int OS_SYNC  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [CNT_W-1:0] div_val,
  input  logic             hi_speed,
  input  logic             sync_mode,
  output logic             os_tick,
  output logic             bit_tick
);

  localparam int PRE_W = ($clog2(SLOW_PRE) > 0) ? $clog2(SLOW_PRE) : 1;
  localparam int OS_W  = ($clog2(OS_ASYNC) > 0) ? $clog2(OS_ASYNC) : 1;

  logic             wrap;
  logic [PRE_W-1:0] pre_last;
  logic [OS_W-1:0]  os_last;

  brg_mode_decode #(
    .SLOW_PRE (SLOW_PRE),
    .OS_ASYNC (OS_ASYNC),
    .OS_SYNC  (OS_SYNC)
  ) u_decode (
    .hi_speed  (hi_speed),
    .sync_mode (sync_mode),
    .pre_last  (pre_last),
    .os_last   (os_last)
  );

  brg_period_counter #(
    .CNT_W (CNT_W)
  ) u_period (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (div_wr),
    .load_val (div_val),
    .wrap     (wrap)
  );

  brg_subdiv #(
    .PRE_W (PRE_W),
    .OS_W  (OS_W)
  ) u_subdiv (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (div_wr),
    .wrap     (wrap),
    .pre_last (pre_last),
    .os_last  (os_last),
    .os_tick  (os_tick),
    .bit_tick (bit_tick)
  );

endmodule

// File: tb/brg_tick_gen_bench.sv
`timescale 1ns/1ps
module brg_tick_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       div_wr = 1'b0;
  logic [7:0] div_val = 8'd0;
  logic       hi_speed = 1'b1;
  logic       sync_mode = 1'b0;
  logic       os_tick;
  logic       bit_tick;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  brg_tick_gen u_brg_tick_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_wr    (div_wr),
    .div_val   (div_val),
    .hi_speed  (hi_speed),
    .sync_mode (sync_mode),
    .os_tick   (os_tick),
    .bit_tick  (bit_tick)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Write X, then record tick cycles counted from the write edge.
  task automatic measure(input logic [7:0] x, input logic hs, input logic sy,
                         input int os_p, input int bit_p, input string tag);
    int os1 = -1, os2 = -1, b1 = -1, b2 = -1;
    int dbl = 0, orphan = 0;
    logic prev = 1'b0;
    @(negedge clk);
    hi_speed = hs; sync_mode = sy; div_val = x; div_wr = 1'b1;
    @(negedge clk);
    div_wr = 1'b0;
    for (int n = 0; n <= 2 * bit_p; n++) begin
      if (n > 0) @(negedge clk);
      if (os_tick) begin
        if (os1 < 0) os1 = n; else if (os2 < 0) os2 = n;
        if (prev) dbl++;
      end
      if (bit_tick) begin
        if (b1 < 0) b1 = n; else if (b2 < 0) b2 = n;
        if (!os_tick) orphan++;
      end
      prev = os_tick;
    end
    check_eq({tag, " first os tick"},  os1, os_p);
    check_eq({tag, " second os tick"}, os2, 2 * os_p);
    check_eq({tag, " first bit tick"}, b1, bit_p);
    check_eq({tag, " second bit tick"}, b2, 2 * bit_p);
    check_eq({tag, " R7 bit without os"}, orphan, 0);
    if (os_p > 1) check_eq({tag, " R7 os wider than one cycle"}, dbl, 0);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check_eq("R1 os_tick in reset", int'(os_tick), 0);
    check_eq("R1 bit_tick in reset", int'(bit_tick), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      check_eq("R1 default divisor 0 gives os every cycle", int'(os_tick), 1);
      @(negedge clk);
    end
  endtask

  task automatic test_restart();
    @(negedge clk);
    hi_speed = 1'b1; sync_mode = 1'b0; div_val = 8'd40; div_wr = 1'b1;
    @(negedge clk);
    div_wr = 1'b0;
    repeat (17) @(negedge clk);
    measure(8'd3, 1'b1, 1'b0, 4, 64, "R6 mid-period rewrite");
  endtask

  initial begin
    test_reset();
    measure(8'd5,   1'b1, 1'b0, 6,    96,    "R2 R3 fast X=5");
    measure(8'd0,   1'b1, 1'b0, 1,    16,    "R8 R3 fast X=0");
    measure(8'd2,   1'b0, 1'b0, 12,   192,   "R4 slow X=2");
    measure(8'd255, 1'b1, 1'b0, 256,  4096,  "R8 R2 fast X=255");
    measure(8'd255, 1'b0, 1'b0, 1024, 16384, "R8 R4 slow X=255");
    measure(8'd7,   1'b0, 1'b1, 8,    32,    "R5 sync hs=0 X=7");
    measure(8'd7,   1'b1, 1'b1, 8,    32,    "R5 sync hs=1 X=7");
    measure(8'd0,   1'b0, 1'b1, 1,    4,     "R5 R8 sync X=0");
    test_restart();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule